// File: doc/BRIEF.md
# Supply-Loss Access Guard Sequencer

This block sits between a host bus controller and a battery-backed static memory. It watches a single digital flag from an external supply comparator. A 1 on the flag means the supply has dropped below the fail threshold. The flag is asynchronous to the block clock, so the block brings it into the clock domain and filters it.

When the block sees a sustained fail, it enters a protected state within a few clock cycles. That is far inside the tens-of-microseconds window the memory allows before writes must stop. While protected, it raises a protect flag, drops its ready flag and forces every memory control strobe to its inactive level. The memory therefore stays in standby and ignores whatever the host drives.

When the supply comes back, protection is not released at once. The block first counts a long recovery interval, 40 ms at the configured clock by default. Any fail sample seen during that interval, even a single cycle long, restarts the whole interval. The block leaves reset in the protected state, so it must complete one full recovery interval before the first access is allowed.

Top module: `pwr_guard_seq`

## Requirements
- R1: During and straight after reset, protect_o is 1, ready_o is 0, and mem_ce_n_o, mem_we_n_o and mem_oe_n_o are all 1.
- R2: While the block is accessible, a fail flag shorter than FILT_CYCLES clock cycles causes no protection: protect_o stays 0 and ready_o stays 1.
- R3: While the block is accessible, a fail flag held for at least FILT_CYCLES cycles raises protect_o exactly FILT_CYCLES+3 rising clock edges after the flag changes. Two of those edges are synchroniser stages, FILT_CYCLES are the stability filter and one is the state register.
- R4: Whenever protect_o is 1, all three active-low memory strobes are 1, whatever the host inputs are.
- R5: Once the fail flag returns to 0 and stays there, ready_o rises and protect_o falls exactly FILT_CYCLES+3+RECOVER_CYCLES rising edges after the flag changed. At one edge earlier, ready_o is still 0. The same timing applies after reset release when the flag is already 0.
- R6: During the recovery interval, a fail flag that lasts a single clock cycle restarts the interval. ready_o then rises RECOVER_CYCLES+4 edges after the cycle in which the glitch was driven, and not at the time originally due.
- R7: While the fail flag stays 1, protect_o stays 1 and ready_o stays 0 indefinitely.
- R8: While ready_o is 1, the strobes follow the host requests, which are active high. mem_ce_n_o is the inverse of host_ce_i. mem_we_n_o is 0 only when host_ce_i and host_we_i are both 1. mem_oe_n_o is 0 only when host_ce_i and host_oe_i are 1 and host_we_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_fail_i | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| host_ce_i | input | 1 | Host chip-select request, active high |
| host_we_i | input | 1 | Host write request, active high |
| host_oe_i | input | 1 | Host output-enable request, active high |
| protect_o | output | 1 | 1 while memory access is blocked |
| ready_o | output | 1 | 1 when the bus controller may access the memory |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |

## Verification
The bench measures both edges of protection to the exact cycle. A design with a missing synchroniser stage or an off-by-one filter would move protect_o, and a recovery counter off by one would raise ready_o one edge early or late. A fail pulse just shorter than the filter length is driven while the block is accessible; a filter that counts wrongly would drop access without cause. A one-cycle glitch is injected halfway through recovery; a design that only reacts to filtered fails, or that resumes counting instead of restarting, would grant access at the original time. The host drives write requests while protection engages, to catch a strobe that is gated on the wrong term.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        PG_NORMAL  = 2'd0,
        PG_PROTECT = 2'd1,
        PG_RECOVER = 2'd2
    } pg_state_e;

endpackage

// File: rtl/pgs_sync.sv
// Two-stage synchroniser; resets to the "fail" level so the block
// assumes a bad supply until proven otherwise.
module pgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.pipe = {cur_q.pipe[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.pipe <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sync_o = cur_q.pipe[STAGES-1];

endmodule

// File: rtl/pgs_filter.sv
// Stability filter: the output level only follows the input after the
// input has differed from it for FILT_CYCLES consecutive samples.
module pgs_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sample_i,
    output logic level_o
);

    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (sample_i == cur_q.lvl) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == LAST) begin
            nxt_d.lvl = sample_i;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.lvl <= 1'b1;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level_o = cur_q.lvl;

    // R2
    level_follows_input_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !$stable(cur_q.lvl) |-> (cur_q.lvl == $past(sample_i))
    );

endmodule

// File: rtl/pgs_fsm.sv
// Protection state machine with recovery counter.
module pgs_fsm
    import pgs_pkg::*;
#(
    parameter int RECOVER_CYCLES = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_fail_i,
    input  logic filt_fail_i,
    output logic ready_o
);

    localparam int CW = (RECOVER_CYCLES < 2) ? 1 : $clog2(RECOVER_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYCLES - 1);

    typedef struct packed {
        pg_state_e     state;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            PG_NORMAL: begin
                if (filt_fail_i) begin
                    nxt_d.state = PG_PROTECT;
                end
            end
            PG_PROTECT: begin
                if (!filt_fail_i && !raw_fail_i) begin
                    nxt_d.state = PG_RECOVER;
                    nxt_d.cnt   = '0;
                end
            end
            PG_RECOVER: begin
                if (raw_fail_i) begin
                    nxt_d.state = PG_PROTECT;
                end else if (cur_q.cnt == LAST) begin
                    nxt_d.state = PG_NORMAL;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                nxt_d.state = PG_PROTECT;
                nxt_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.state <= PG_PROTECT;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ready_o = (cur_q.state == PG_NORMAL);

    // R3
    fail_engages_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (cur_q.state == PG_NORMAL && filt_fail_i) |=> (cur_q.state == PG_PROTECT)
    );

    // R6
    glitch_restarts_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (cur_q.state == PG_RECOVER && raw_fail_i) |=> (cur_q.state == PG_PROTECT)
    );

    // R5
    normal_only_from_recover_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> ($past(cur_q.state) == PG_RECOVER)
    );

    // R7
    held_fail_blocks_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (filt_fail_i && raw_fail_i && cur_q.state != PG_NORMAL) |=> !ready_o
    );

endmodule

// File: rtl/pgs_gate.sv
// Strobe gating between host requests and memory pins.
module pgs_gate (
    input  logic allow_i,
    input  logic host_ce_i,
    input  logic host_we_i,
    input  logic host_oe_i,
    output logic mem_ce_n_o,
    output logic mem_we_n_o,
    output logic mem_oe_n_o
);

    logic sel;

    always_comb begin
        sel        = allow_i & host_ce_i;
        mem_ce_n_o = ~sel;
        mem_we_n_o = ~(sel & host_we_i);
        mem_oe_n_o = ~(sel & host_oe_i & ~host_we_i);
    end

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
    parameter int CLK_HZ         = 100_000_000,
    parameter int RECOVER_MS     = 40,
    parameter int RECOVER_CYCLES = (CLK_HZ / 1000) * RECOVER_MS,
    parameter int FILT_CYCLES    = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_fail_i,
    input  logic host_ce_i,
    input  logic host_we_i,
    input  logic host_oe_i,
    output logic protect_o,
    output logic ready_o,
    output logic mem_ce_n_o,
    output logic mem_we_n_o,
    output logic mem_oe_n_o
);

    logic fail_sync;
    logic fail_filt;
    logic ready;

    pgs_sync #(.STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (supply_fail_i),
        .sync_o  (fail_sync)
    );

    pgs_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (fail_sync),
        .level_o  (fail_filt)
    );

    pgs_fsm #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raw_fail_i  (fail_sync),
        .filt_fail_i (fail_filt),
        .ready_o     (ready)
    );

    pgs_gate u_gate (
        .allow_i    (ready),
        .host_ce_i  (host_ce_i),
        .host_we_i  (host_we_i),
        .host_oe_i  (host_oe_i),
        .mem_ce_n_o (mem_ce_n_o),
        .mem_we_n_o (mem_we_n_o),
        .mem_oe_n_o (mem_oe_n_o)
    );

    assign ready_o   = ready;
    assign protect_o = ~ready;

    // R4
    strobes_idle_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        protect_o |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o)
    );

    // R8
    write_needs_ready_chk: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !mem_we_n_o |-> (ready_o && host_ce_i && host_we_i)
    );

endmodule

// File: tb/pwr_guard_seq_tb.sv
module pwr_guard_seq_tb;

    localparam int FILT = 4;
    localparam int RC   = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_fail = 1'b0;
    logic h_ce = 1'b0, h_we = 1'b0, h_oe = 1'b0;
    logic protect, ready, ce_n, we_n, oe_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  prot;
        logic  rdy;
        string req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_guard_seq #(
        .RECOVER_CYCLES (RC),
        .FILT_CYCLES    (FILT)
    ) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .supply_fail_i (supply_fail),
        .host_ce_i     (h_ce),
        .host_we_i     (h_we),
        .host_oe_i     (h_oe),
        .protect_o     (protect),
        .ready_o       (ready),
        .mem_ce_n_o    (ce_n),
        .mem_we_n_o    (we_n),
        .mem_oe_n_o    (oe_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int at, input logic p, input logic r, input string req);
        exp_t e;
        e.at = at; e.prot = p; e.rdy = r; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compares queued expectations at the matching cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.at < cyc) begin
                check({e.req, " missed slot"}, 8'd0, 8'd1);
            end else begin
                check(e.req, {6'd0, protect, ready}, {6'd0, e.prot, e.rdy});
            end
        end
    end

    task automatic strobes(input string req, input logic c, input logic w, input logic o);
        check(req, {5'd0, ce_n, we_n, oe_n}, {5'd0, c, w, o});
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        int c;
        int c2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 protect/ready", {6'd0, protect, ready}, 8'b10);
        h_ce = 1'b1; h_we = 1'b1; h_oe = 1'b1;
        #1 strobes("R1 strobes", 1'b1, 1'b1, 1'b1);
        h_ce = 1'b0; h_we = 1'b0; h_oe = 1'b0;

        // R5 first recovery after reset
        @(negedge clk);
        c = cyc;
        rst_n = 1'b1;
        expect_at(c + 1, 1'b1, 1'b0, "R1 after release");
        expect_at(c + FILT + 2 + RC, 1'b1, 1'b0, "R5 not yet ready");
        expect_at(c + FILT + 3 + RC, 1'b0, 1'b1, "R5 ready after reset");
        repeat (FILT + RC + 6) @(negedge clk);

        // R8 pass-through in normal operation
        for (int i = 0; i < 8; i++) begin
            logic ce, we, oe;
            {ce, we, oe} = 3'(i);
            h_ce = ce; h_we = we; h_oe = oe;
            #1 strobes("R8 passthrough", ~ce, ~(ce & we), ~(ce & oe & ~we));
            @(negedge clk);
        end
        h_ce = 1'b0; h_we = 1'b0; h_oe = 1'b0;

        // R2 short fail pulse is filtered
        c = cyc;
        supply_fail = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        supply_fail = 1'b0;
        expect_at(c + FILT + 3, 1'b0, 1'b1, "R2 short pulse ignored");
        expect_at(c + FILT + 8, 1'b0, 1'b1, "R2 short pulse ignored late");
        repeat (FILT + 10) @(negedge clk);

        // R3 fail engages with exact latency, host writing meanwhile
        h_ce = 1'b1; h_we = 1'b1; h_oe = 1'b0;
        c = cyc;
        supply_fail = 1'b1;
        expect_at(c + FILT + 2, 1'b0, 1'b1, "R3 not before latency");
        expect_at(c + FILT + 3, 1'b1, 1'b0, "R3 protect at latency");
        repeat (FILT + 5) @(negedge clk);
        // R4 strobes idle despite host requests
        #1 strobes("R4 write blocked", 1'b1, 1'b1, 1'b1);
        h_we = 1'b0; h_oe = 1'b1;
        #1 strobes("R4 read blocked", 1'b1, 1'b1, 1'b1);

        // R7 held fail never releases
        c = cyc;
        expect_at(c + RC, 1'b1, 1'b0, "R7 held fail");
        expect_at(c + 2 * RC, 1'b1, 1'b0, "R7 held fail long");
        expect_at(c + 3 * RC, 1'b1, 1'b0, "R7 held fail longer");
        repeat (3 * RC + 2) @(negedge clk);

        // R6 glitch in the middle of recovery restarts the interval
        h_ce = 1'b0; h_oe = 1'b0;
        c = cyc;
        supply_fail = 1'b0;
        c2 = c + FILT + 3 + RC / 2;
        expect_at(c + FILT + 3 + RC, 1'b1, 1'b0, "R6 original release suppressed");
        expect_at(c2 + 3 + RC, 1'b1, 1'b0, "R6 not yet ready");
        expect_at(c2 + 4 + RC, 1'b0, 1'b1, "R6 ready after restart");
        repeat (c2 - c) @(negedge clk);
        supply_fail = 1'b1;
        @(negedge clk);
        supply_fail = 1'b0;
        repeat (RC + 10) @(negedge clk);

        if (sb.size() != 0) check("R6 pending expectations", 8'(sb.size()), 8'd0);
        check("R5 final ready", {7'd0, ready}, 8'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule